// File: doc/BRIEF.md
# Area-Gated Auxiliary Read Strobe

This block produces a second, dedicated active-low read strobe for the external bus. The strobe goes low only when the bus is reading and the current cycle's address area belongs to a group whose enable bit is set. Software sets those enables through one byte-wide control register. The bus cycle arrives with its area number already decoded. The block adds no register stage on the strobe path, so the auxiliary strobe keeps exactly the edges of the main read strobe.

The register has eight bit positions but only seven enables. Most enables cover a pair of neighbouring areas and one covers a single area. Bit 3 has no function. There are two reset inputs. A cold reset clears every enable. A hot reset leaves the enables as they are, blocks register writes and holds the strobe inactive while it is asserted.

Top module: `aux_rd_gate`

## Requirements
- R1: The enable register answers at address ENA_ADDR (default 8'h38). A write there with reg_we high takes effect at the next rising clock edge. Read-back is combinational and returns the last value written, masked by R2. Any other address reads 8'h00, and a write to any other address leaves the enables unchanged.
- R2: Bit 3 is not implemented. It always reads 0, and writing 1 to it changes nothing, including the strobe.
- R3: While cold_rst_n is low, all enables are 0. After cold reset is released, the register reads 8'h00 and no area asserts the strobe.
- R4: While hot_rst_n is low, the enables keep their values, register writes are ignored and aux_rd_n stays high. After release, read-back equals the value held before the hot reset.
- R5: The area-to-bit mapping is: bit 0 covers areas 4 and 5, bit 1 covers area 6, bit 2 covers areas 7 and 8, bit 4 covers areas 11 and 12, bit 5 covers areas 13 and 14, bit 6 covers areas 15 and 16, and bit 7 covers areas 17 and 18. An enable bit has no effect on any area outside its own group.
- R6: aux_rd_n is low in the same cycle, with no added latency, exactly when all of the following hold: bus_rd_n is low, bus_area is in a covered group, that group's enable bit is 1, and both resets are high.
- R7: Areas 0 to 3, 9, 10 and 19 to 31 never assert aux_rd_n, whatever the enables hold.
- R8: While bus_rd_n is high (idle or write cycles), aux_rd_n is high, even with every enable set.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Register clock |
| cold_rst_n | input | 1 | Asynchronous active-low cold reset; clears the enables |
| hot_rst_n | input | 1 | Active-low hot reset; keeps the enables, blocks writes and the strobe |
| reg_addr | input | ADDR_W | Register port address |
| reg_wdata | input | 8 | Register write data |
| reg_we | input | 1 | Register write enable |
| reg_rdata | output | 8 | Register read-back data |
| bus_area | input | AREA_W | Decoded area number of the current bus cycle |
| bus_rd_n | input | 1 | Main bus read strobe, active low |
| aux_rd_n | output | 1 | Auxiliary area-gated read strobe, active low |

## Verification
A vector table pairs a single set enable with an area inside its own group, at the group's edges and next to it. This shows whether a bit covers both areas of its pair and only those. A full sweep sets each enable bit alone and reads from all 32 areas. This separates a wrong bit index from a wrong group width and finds a strobe leaking into an uncovered area. Patterns with every enable set cover three cases: the main strobe high (writes), bit 3 written alone, and reads with either reset asserted. These show that the strobe is gated by the main read and by the resets and not only by the enables.

// File: rtl/aux_rd_pkg.sv
package aux_rd_pkg;

  localparam int unsigned NUM_BITS  = 8;
  localparam logic [7:0]  IMPL_MASK = 8'hF7;

  typedef struct packed {
    logic       hit;
    logic [2:0] idx;
  } area_map_t;

  // Map an area number to the enable bit that covers it.
  function automatic area_map_t area_map(input int unsigned area);
    area_map_t m;
    m.hit = 1'b1;
    case (area)
      4, 5:   m.idx = 3'd0;
      6:      m.idx = 3'd1;
      7, 8:   m.idx = 3'd2;
      11, 12: m.idx = 3'd4;
      13, 14: m.idx = 3'd5;
      15, 16: m.idx = 3'd6;
      17, 18: m.idx = 3'd7;
      default: begin
        m.hit = 1'b0;
        m.idx = 3'd0;
      end
    endcase
    return m;
  endfunction

  // Keep only the implemented enable positions.
  function automatic logic [7:0] impl_bits(input logic [7:0] d);
    return d & IMPL_MASK;
  endfunction

endpackage

// File: rtl/aux_rd_ena_reg.sv
module aux_rd_ena_reg
  import aux_rd_pkg::*;
#(
  parameter int unsigned ADDR_W   = 8,
  parameter logic [ADDR_W-1:0] ENA_ADDR = 8'h38
) (
  input  logic              clk,
  input  logic              cold_rst_n,
  input  logic              hot_rst_n,
  input  logic [ADDR_W-1:0] reg_addr,
  input  logic [7:0]        reg_wdata,
  input  logic              reg_we,
  output logic [7:0]        reg_rdata,
  output logic [7:0]        ena_q,
  output logic              wr_hit
);

  logic addr_hit;

  assign addr_hit = (reg_addr == ENA_ADDR);
  assign wr_hit   = addr_hit && reg_we && hot_rst_n;

  // Only the cold reset clears the enables.
  always_ff @(posedge clk or negedge cold_rst_n) begin
    if (!cold_rst_n)
      ena_q <= '0;
    else if (wr_hit)
      ena_q <= impl_bits(reg_wdata);
  end

  assign reg_rdata = addr_hit ? ena_q : 8'h00;

endmodule

// File: rtl/aux_rd_area_dec.sv
module aux_rd_area_dec
  import aux_rd_pkg::*;
#(
  parameter int unsigned AREA_W = 5
) (
  input  logic [AREA_W-1:0]   bus_area,
  output logic [NUM_BITS-1:0] area_sel
);

  area_map_t map;

  assign map = area_map(int'(unsigned'(bus_area)));

  for (genvar b = 0; b < NUM_BITS; b++) begin : g_sel
    assign area_sel[b] = map.hit && (map.idx == 3'(b));
  end

endmodule

// File: rtl/aux_rd_strobe.sv
module aux_rd_strobe
  import aux_rd_pkg::*;
(
  input  logic                cold_rst_n,
  input  logic                hot_rst_n,
  input  logic                bus_rd_n,
  input  logic [NUM_BITS-1:0] area_sel,
  input  logic [NUM_BITS-1:0] ena_q,
  output logic                area_hit,
  output logic                aux_rd_n
);

  assign area_hit = |(area_sel & ena_q);
  // Combinational gate: the strobe keeps the main read strobe's timing.
  assign aux_rd_n = ~(~bus_rd_n & area_hit & cold_rst_n & hot_rst_n);

endmodule

// File: rtl/aux_rd_gate.sv
module aux_rd_gate
  import aux_rd_pkg::*;
#(
  parameter int unsigned ADDR_W   = 8,
  parameter int unsigned AREA_W   = 5,
  parameter logic [ADDR_W-1:0] ENA_ADDR = 8'h38
) (
  input  logic              clk,
  input  logic              cold_rst_n,
  input  logic              hot_rst_n,
  input  logic [ADDR_W-1:0] reg_addr,
  input  logic [7:0]        reg_wdata,
  input  logic              reg_we,
  output logic [7:0]        reg_rdata,
  input  logic [AREA_W-1:0] bus_area,
  input  logic              bus_rd_n,
  output logic              aux_rd_n
);

  logic [NUM_BITS-1:0] ena_q;
  logic [NUM_BITS-1:0] area_sel;
  logic                wr_hit;
  logic                area_hit;

  aux_rd_ena_reg #(.ADDR_W(ADDR_W), .ENA_ADDR(ENA_ADDR)) u_reg (
    .clk        (clk),
    .cold_rst_n (cold_rst_n),
    .hot_rst_n  (hot_rst_n),
    .reg_addr   (reg_addr),
    .reg_wdata  (reg_wdata),
    .reg_we     (reg_we),
    .reg_rdata  (reg_rdata),
    .ena_q      (ena_q),
    .wr_hit     (wr_hit)
  );

  aux_rd_area_dec #(.AREA_W(AREA_W)) u_dec (
    .bus_area (bus_area),
    .area_sel (area_sel)
  );

  aux_rd_strobe u_stb (
    .cold_rst_n (cold_rst_n),
    .hot_rst_n  (hot_rst_n),
    .bus_rd_n   (bus_rd_n),
    .area_sel   (area_sel),
    .ena_q      (ena_q),
    .area_hit   (area_hit),
    .aux_rd_n   (aux_rd_n)
  );

endmodule

// File: rtl/aux_rd_chk.sv
module aux_rd_chk
  import aux_rd_pkg::*;
#(
  parameter int unsigned ADDR_W   = 8,
  parameter logic [ADDR_W-1:0] ENA_ADDR = 8'h38
) (
  input logic                clk,
  input logic                cold_rst_n,
  input logic                hot_rst_n,
  input logic [ADDR_W-1:0]   reg_addr,
  input logic [7:0]          reg_wdata,
  input logic                reg_we,
  input logic                bus_rd_n,
  input logic                aux_rd_n,
  input logic [NUM_BITS-1:0] ena_q,
  input logic [NUM_BITS-1:0] area_sel
);

  assert_write_takes_R1: assert property (@(posedge clk) disable iff (!cold_rst_n)
    (reg_we && reg_addr == ENA_ADDR && hot_rst_n) |=> (ena_q == ($past(reg_wdata) & IMPL_MASK)));

  assert_other_addr_keeps_R1: assert property (@(posedge clk) disable iff (!cold_rst_n)
    (reg_addr != ENA_ADDR) |=> $stable(ena_q));

  assert_bit3_zero_R2: assert property (@(posedge clk) disable iff (!cold_rst_n)
    ena_q[3] == 1'b0);

  assert_hot_keeps_R4: assert property (@(posedge clk) disable iff (!cold_rst_n)
    !hot_rst_n |=> $stable(ena_q));

  assert_hot_quiet_R4: assert property (@(posedge clk) disable iff (!cold_rst_n)
    !hot_rst_n |-> aux_rd_n);

  assert_single_group_R5: assert property (@(posedge clk) disable iff (!cold_rst_n)
    $onehot0(area_sel));

  assert_uncovered_quiet_R7: assert property (@(posedge clk) disable iff (!cold_rst_n)
    (area_sel == '0) |-> aux_rd_n);

  assert_read_only_R8: assert property (@(posedge clk) disable iff (!cold_rst_n)
    bus_rd_n |-> aux_rd_n);

endmodule

bind aux_rd_gate aux_rd_chk #(.ADDR_W(ADDR_W), .ENA_ADDR(ENA_ADDR)) u_chk (
  .clk        (clk),
  .cold_rst_n (cold_rst_n),
  .hot_rst_n  (hot_rst_n),
  .reg_addr   (reg_addr),
  .reg_wdata  (reg_wdata),
  .reg_we     (reg_we),
  .bus_rd_n   (bus_rd_n),
  .aux_rd_n   (aux_rd_n),
  .ena_q      (ena_q),
  .area_sel   (area_sel)
);

// File: tb/sim_aux_rd_gate.sv
`timescale 1ns/1ps
module sim_aux_rd_gate;

  localparam logic [7:0] ADDR = 8'h38;

  logic       clk = 1'b0;
  logic       cold_rst_n = 1'b0;
  logic       hot_rst_n = 1'b1;
  logic [7:0] reg_addr = ADDR;
  logic [7:0] reg_wdata = 8'h00;
  logic       reg_we = 1'b0;
  logic [7:0] reg_rdata;
  logic [4:0] bus_area = 5'd0;
  logic       bus_rd_n = 1'b1;
  logic       aux_rd_n;

  int n_chk = 0;
  int n_fail = 0;

  always #5 clk = ~clk;

  aux_rd_gate u0 (
    .clk(clk), .cold_rst_n(cold_rst_n), .hot_rst_n(hot_rst_n),
    .reg_addr(reg_addr), .reg_wdata(reg_wdata), .reg_we(reg_we),
    .reg_rdata(reg_rdata), .bus_area(bus_area), .bus_rd_n(bus_rd_n),
    .aux_rd_n(aux_rd_n)
  );

  // Vector: {enable byte written, area, bus_rd_n, expected aux_rd_n}
  localparam int NV = 16;
  localparam logic [14:0] VEC [NV] = '{
    {8'h01, 5'd4,  1'b0, 1'b0},
    {8'h01, 5'd5,  1'b0, 1'b0},
    {8'h01, 5'd6,  1'b0, 1'b1},
    {8'h02, 5'd6,  1'b0, 1'b0},
    {8'h04, 5'd8,  1'b0, 1'b0},
    {8'h10, 5'd11, 1'b0, 1'b0},
    {8'h20, 5'd14, 1'b0, 1'b0},
    {8'h40, 5'd15, 1'b0, 1'b0},
    {8'h80, 5'd18, 1'b0, 1'b0},
    {8'hFF, 5'd19, 1'b0, 1'b1},
    {8'hFF, 5'd3,  1'b0, 1'b1},
    {8'hFF, 5'd9,  1'b0, 1'b1},
    {8'hFF, 5'd10, 1'b0, 1'b1},
    {8'hFF, 5'd17, 1'b1, 1'b1},
    {8'h7F, 5'd17, 1'b0, 1'b1},
    {8'h08, 5'd9,  1'b0, 1'b1}
  };

  // Bench restatement of the area grouping; -1 means not covered.
  function automatic int exp_bit(int a);
    if (a == 4 || a == 5) return 0;
    if (a == 6) return 1;
    if (a == 7 || a == 8) return 2;
    if (a >= 11 && a <= 18) return (a - 11) / 2 + 4;
    return -1;
  endfunction

  task automatic check(string req, logic [7:0] act, logic [7:0] exp);
    n_chk++;
    if (act !== exp) begin
      n_fail++;
      $display("FAIL %s: actual %h expected %h", req, act, exp);
    end
  endtask

  task automatic wr(logic [7:0] a, logic [7:0] d);
    @(negedge clk);
    reg_addr = a; reg_wdata = d; reg_we = 1'b1;
    @(negedge clk);
    reg_we = 1'b0; reg_addr = ADDR;
    #1;
  endtask

  task automatic rd_bus(logic [4:0] a, logic r);
    bus_area = a; bus_rd_n = r;
    #1;
  endtask

  initial begin : watchdog
    #2_000_000;
    n_fail++;
    $display("FAIL watchdog: actual timeout expected finish");
    $display("End of test - %0d assertions evaluated, %0d failures", n_chk, n_fail);
    $finish;
  end

  initial begin : main
    repeat (3) @(negedge clk);
    cold_rst_n = 1'b1;
    #1;
    // R3: reset state
    check("R3 reset readback", reg_rdata, 8'h00);
    rd_bus(5'd4, 1'b0);
    check("R3 reset strobe", {7'd0, aux_rd_n}, 8'h01);
    rd_bus(5'd0, 1'b1);

    // Vector table: R5 R6 R7 R8 R2 R1
    for (int i = 0; i < NV; i++) begin
      wr(ADDR, VEC[i][14:7]);
      check("R1/R2 readback", reg_rdata, VEC[i][14:7] & 8'hF7);
      rd_bus(VEC[i][6:2], VEC[i][1]);
      check($sformatf("R6 vector %0d", i), {7'd0, aux_rd_n}, {7'd0, VEC[i][0]});
      rd_bus(5'd0, 1'b1);
    end

    // Sweep: each bit alone against every area (R5, R7)
    for (int b = 0; b < 8; b++) begin
      wr(ADDR, 8'(1 << b));
      for (int a = 0; a < 32; a++) begin
        rd_bus(5'(a), 1'b0);
        check($sformatf("R5/R7 bit %0d area %0d", b, a), {7'd0, aux_rd_n},
              {7'd0, !(b != 3 && exp_bit(a) == b)});
      end
      rd_bus(5'd0, 1'b1);
    end

    // R1: other address reads 0 and writes there are ignored
    wr(ADDR, 8'hA5);
    reg_addr = 8'h39; #1;
    check("R1 other addr read", reg_rdata, 8'h00);
    wr(8'h39, 8'h00);
    check("R1 other addr write", reg_rdata, 8'hA5);

    // R4: hot reset keeps enables, blocks writes and the strobe
    wr(ADDR, 8'hFF);
    @(negedge clk);
    hot_rst_n = 1'b0;
    rd_bus(5'd4, 1'b0);
    check("R4 strobe quiet", {7'd0, aux_rd_n}, 8'h01);
    reg_wdata = 8'h00; reg_we = 1'b1;
    @(negedge clk);
    reg_we = 1'b0;
    @(negedge clk);
    hot_rst_n = 1'b1;
    #1;
    check("R4 enables kept", reg_rdata, 8'hF7);
    check("R4 strobe back", {7'd0, aux_rd_n}, 8'h00);
    rd_bus(5'd0, 1'b1);

    // R3: cold reset clears
    @(negedge clk);
    cold_rst_n = 1'b0;
    #1;
    check("R3 cold clears", reg_rdata, 8'h00);
    @(negedge clk);
    cold_rst_n = 1'b1;
    rd_bus(5'd17, 1'b0);
    check("R3 after cold strobe", {7'd0, aux_rd_n}, 8'h01);
    rd_bus(5'd0, 1'b1);

    $display("End of test - %0d assertions evaluated, %0d failures", n_chk, n_fail);
    $finish;
  end

endmodule